// File: doc/BRIEF.md
# Selectable-Polynomial Parallel PRBS Source

This block produces a pseudo-random bit stream for exercising a serial link without any protocol layer above it. One shared linear feedback shift register runs one of five polynomials, chosen at run time, and unrolls it so that each clock yields a whole parallel word of either 10 or 64 fresh bits. A final multiplexer decides whether the word leaving the block is the generated pattern or the normal payload word. The serializer sits downstream and is outside this block.

The pattern is chosen by a 4-bit one-hot field plus one extra bit. The narrow 10-bit width is only allowed with the 9-stage polynomial. Any code or combination that is not legal falls back to the 31-stage polynomial at 64 bits. Changing the effective pattern or width restarts the register from its all-ones seed, so a receiver can lock onto a known starting point.

Top module: `prbs_par_gen`

## Requirements
- R1: The five polynomials are 1+x^6+x^7, 1+x^5+x^9, 1+x^14+x^15, 1+x^18+x^23 and 1+x^28+x^31. Each is a shift register: the fed-back bit is the XOR of stage n and stage t (stage 1 holds the newest bit), and each fed-back bit is also the next output bit. As a result, the 7-stage pattern at 64 bits repeats its words every 127 enabled clocks.
- R2: With {pat_ext, pat_field} equal to 0_0001, 0_0010, 0_0100 or 0_1000, the 7, 9, 15 or 23-stage polynomial is selected. The code 1_0000 selects the 31-stage polynomial.
- R3: When narrow_sel=1 and the 9-stage polynomial is selected, each word carries 10 new bits in data_out[9:0], and data_out[63:10] is zero. With narrow_sel=0 it carries 64 new bits.
- R4: Any other code, and any polynomial other than the 9-stage one with narrow_sel=1, behaves exactly like code 1_0000 at 64 bits.
- R5: When prbs_sel=1, data_out is the generated word. When prbs_sel=0, data_out equals payload in the same cycle.
- R6: When gen_en=0 and the configuration is unchanged, the register state and the generated word hold their values.
- R7: Each enabled clock advances the register by 10 or 64 steps. The earliest bit of the word sits at bit 0. Starting from the seed, the first 10-bit word of the 9-stage pattern is 0x1E0.
- R8: While rst is high, the state is loaded with all ones for the 31-stage polynomial at 64 bits, and the generated word is zero.
- R9: On the first clock after the effective configuration changes, the state is reloaded with all ones for the new length and the generated word reads zero. Enabled clocks after that produce the sequence from the seed.
- R10: The register state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Advances the generator when high |
| pat_field | input | 4 | One-hot polynomial code |
| pat_ext | input | 1 | Extra code bit selecting the 31-stage polynomial |
| narrow_sel | input | 1 | Requests the 10-bit width |
| prbs_sel | input | 1 | Chooses the generated word over payload |
| payload | input | 64 | Normal data word |
| data_out | output | 64 | Word sent toward the serializer |

## Verification
The checks assume that gen_en, the pattern code, narrow_sel and prbs_sel are synchronous to clk and change only between edges. They also assume that payload is an ordinary data word with no timing relation to the generator. The hold property applies only when the decoded configuration matches the registered one, because a change of configuration reseeds the register even while gen_en is low. The stimulus drives every input on the falling edge. It holds each configuration long enough for the sequence checks, and it changes configuration at random only occasionally, mixing legal and illegal codes so that reseeds are exercised without hiding the stepping.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
    localparam int STATE_W  = 31;
    localparam int WIDE_W   = 64;
    localparam int NARROW_W = 10;

    typedef enum logic [2:0] {PAT7, PAT9, PAT15, PAT23, PAT31} pat_e;

    typedef struct packed {
        pat_e pat;
        logic narrow;
    } cfg_t;

    typedef struct packed {
        logic [STATE_W-1:0] st;
        logic [WIDE_W-1:0]  bits;
    } adv_t;

    function automatic int pat_len(pat_e p);
        case (p)
            PAT7:    return 7;
            PAT9:    return 9;
            PAT15:   return 15;
            PAT23:   return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int pat_tap(pat_e p);
        case (p)
            PAT7:    return 6;
            PAT9:    return 5;
            PAT15:   return 14;
            PAT23:   return 18;
            default: return 28;
        endcase
    endfunction

    function automatic logic [STATE_W-1:0] seed_of(pat_e p);
        logic [63:0] m;
        m = (64'd1 << pat_len(p)) - 64'd1;
        return m[STATE_W-1:0];
    endfunction

    // Unrolled serial steps; the bit produced first lands at index 0.
    function automatic adv_t advance(logic [STATE_W-1:0] st, pat_e p, logic narrow);
        adv_t r;
        logic fb;
        int   n;
        int   t;
        int   steps;
        n      = pat_len(p);
        t      = pat_tap(p);
        steps  = narrow ? NARROW_W : WIDE_W;
        r.st   = st;
        r.bits = '0;
        for (int i = 0; i < WIDE_W; i++) begin
            if (i < steps) begin
                fb        = r.st[n-1] ^ r.st[t-1];
                r.st      = {r.st[STATE_W-2:0], fb} & seed_of(p);
                r.bits[i] = fb;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/prbs_cfg_decode.sv
module prbs_cfg_decode
    import prbs_pkg::*;
(
    input  logic [3:0] pat_field,
    input  logic       pat_ext,
    input  logic       narrow_req,
    output cfg_t       cfg
);
    always_comb begin
        cfg.pat    = PAT31;
        cfg.narrow = 1'b0;
        case ({pat_ext, pat_field})
            5'b0_0001: cfg.pat = PAT7;
            5'b0_0010: cfg.pat = PAT9;
            5'b0_0100: cfg.pat = PAT15;
            5'b0_1000: cfg.pat = PAT23;
            5'b1_0000: cfg.pat = PAT31;
            default:   cfg.pat = PAT31;
        endcase
        if (narrow_req) begin
            if (cfg.pat == PAT9) cfg.narrow = 1'b1;
            else                 cfg.pat    = PAT31;
        end
    end
endmodule

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
    import prbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  cfg_t               cfg,
    output cfg_t               cfg_q,
    output logic [STATE_W-1:0] state_q,
    output logic [WIDE_W-1:0]  word_q
);
    adv_t nxt;

    always_comb nxt = advance(state_q, cfg_q.pat, cfg_q.narrow);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{pat: PAT31, narrow: 1'b0};
            state_q <= seed_of(PAT31);
            word_q  <= '0;
        end else if (cfg != cfg_q) begin
            cfg_q   <= cfg;
            state_q <= seed_of(cfg.pat);
            word_q  <= '0;
        end else if (en) begin
            state_q <= nxt.st;
            word_q  <= nxt.bits;
        end
    end
endmodule

// File: rtl/prbs_out_mux.sv
module prbs_out_mux #(
    parameter int W = 64
) (
    input  logic         use_prbs,
    input  logic [W-1:0] prbs_word,
    input  logic [W-1:0] pay_word,
    output logic [W-1:0] mux_out
);
    always_comb mux_out = use_prbs ? prbs_word : pay_word;
endmodule

// File: rtl/prbs_par_gen.sv
module prbs_par_gen
    import prbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_en,
    input  logic [3:0]        pat_field,
    input  logic              pat_ext,
    input  logic              narrow_sel,
    input  logic              prbs_sel,
    input  logic [WIDE_W-1:0] payload,
    output logic [WIDE_W-1:0] data_out
);
    cfg_t               cfg_eff;
    cfg_t               cfg_q;
    logic [STATE_W-1:0] state_q;
    logic [WIDE_W-1:0]  word_q;

    prbs_cfg_decode u_dec (
        .pat_field (pat_field),
        .pat_ext   (pat_ext),
        .narrow_req(narrow_sel),
        .cfg       (cfg_eff)
    );

    prbs_lfsr_core u_core (
        .clk    (clk),
        .rst    (rst),
        .en     (gen_en),
        .cfg    (cfg_eff),
        .cfg_q  (cfg_q),
        .state_q(state_q),
        .word_q (word_q)
    );

    prbs_out_mux #(.W(WIDE_W)) u_mux (
        .use_prbs (prbs_sel),
        .prbs_word(word_q),
        .pay_word (payload),
        .mux_out  (data_out)
    );
endmodule

// File: rtl/prbs_par_gen_chk.sv
module prbs_par_gen_chk
    import prbs_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               gen_en,
    input logic               prbs_sel,
    input logic [WIDE_W-1:0]  payload,
    input logic [WIDE_W-1:0]  data_out,
    input cfg_t               cfg_eff,
    input cfg_t               cfg_q,
    input logic [STATE_W-1:0] state_q,
    input logic [WIDE_W-1:0]  word_q
);
    a_r5_payload_pass: assert property (@(posedge clk) disable iff (rst)
        !prbs_sel |-> data_out == payload);

    a_r5_prbs_drive: assert property (@(posedge clk) disable iff (rst)
        prbs_sel |-> data_out == word_q);

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!gen_en && cfg_eff == cfg_q) |=> ($stable(state_q) && $stable(word_q)));

    a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_q.narrow |-> word_q[WIDE_W-1:NARROW_W] == '0);

    a_r4_narrow_only_nine: assert property (@(posedge clk) disable iff (rst)
        cfg_eff.narrow |-> cfg_eff.pat == PAT9);

    a_r9_reseed: assert property (@(posedge clk) disable iff (rst)
        (cfg_eff != cfg_q) |=> (state_q == seed_of(cfg_q.pat) && word_q == '0));

    a_r10_no_lockup: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);
endmodule

bind prbs_par_gen prbs_par_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .gen_en  (gen_en),
    .prbs_sel(prbs_sel),
    .payload (payload),
    .data_out(data_out),
    .cfg_eff (cfg_eff),
    .cfg_q   (cfg_q),
    .state_q (state_q),
    .word_q  (word_q)
);

// File: tb/prbs_par_gen_test.sv
`timescale 1ns/1ps
module prbs_par_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen_en = 1'b0;
    logic [3:0]  pat_field = 4'b0000;
    logic        pat_ext = 1'b1;
    logic        narrow_sel = 1'b0;
    logic        prbs_sel = 1'b1;
    logic [63:0] payload = '0;
    logic [63:0] data_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    bit [30:0] ms;
    bit [63:0] mw;
    int        mlen;
    bit        mnar;

    always #10 clk = ~clk;

    prbs_par_gen uut (
        .clk(clk), .rst(rst), .gen_en(gen_en), .pat_field(pat_field),
        .pat_ext(pat_ext), .narrow_sel(narrow_sel), .prbs_sel(prbs_sel),
        .payload(payload), .data_out(data_out)
    );

    function automatic int want_len(bit [3:0] f, bit e, bit n);
        int l;
        if      (!e && f == 4'h1) l = 7;
        else if (!e && f == 4'h2) l = 9;
        else if (!e && f == 4'h4) l = 15;
        else if (!e && f == 4'h8) l = 23;
        else                      l = 31;
        if (n && l != 9) l = 31;
        return l;
    endfunction

    function automatic int tap_for(int l);
        return (l == 7) ? 6 : (l == 9) ? 5 : (l == 15) ? 14 : (l == 23) ? 18 : 28;
    endfunction

    function automatic bit [30:0] ones(int l);
        bit [30:0] v = '0;
        for (int k = 0; k < l; k++) v[k] = 1'b1;
        return v;
    endfunction

    task automatic model_edge();
        int  l;
        bit  n;
        bit  fb;
        int  cnt;
        if (rst) begin
            mlen = 31; mnar = 0; ms = ones(31); mw = '0;
        end else begin
            l = want_len(pat_field, pat_ext, narrow_sel);
            n = narrow_sel && (l == 9);
            if (l != mlen || n != mnar) begin
                mlen = l; mnar = n; ms = ones(l); mw = '0;
            end else if (gen_en) begin
                cnt = mnar ? 10 : 64;
                mw = '0;
                for (int k = 0; k < cnt; k++) begin
                    fb = ms[mlen-1] ^ ms[tap_for(mlen)-1];
                    ms = ((ms << 1) | 31'(fb)) & ones(mlen);
                    mw[k] = fb;
                end
            end
        end
    endtask

    task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_eq(tag, data_out, prbs_sel ? mw : payload);
    endtask

    task automatic set_cfg(bit [3:0] f, bit e, bit n);
        pat_field = f; pat_ext = e; narrow_sel = n;
    endtask

    initial begin
        logic [63:0] first;
        void'($urandom(32'd4711));
        @(negedge clk);
        tick("R8");
        tick("R8");
        check_eq("R8 reset word zero", data_out, 64'h0);
        rst = 1'b0;

        // 9-stage, 10-bit: known first word
        set_cfg(4'h2, 0, 1); gen_en = 1;
        tick("R9");
        check_eq("R9 reseed word zero", data_out, 64'h0);
        tick("R7");
        check_eq("R7 first narrow word", data_out, 64'h1E0);
        for (int i = 0; i < 10; i++) begin
            tick("R3");
            check_eq("R3 upper bits zero", {data_out[63:10], 10'h0}, 64'h0);
        end

        // 7-stage periodicity
        set_cfg(4'h1, 0, 0);
        tick("R9");
        tick("R1");
        first = data_out;
        for (int i = 0; i < 127; i++) tick("R1");
        check_eq("R1 period 127 words", data_out, first);

        // hold
        gen_en = 0;
        for (int i = 0; i < 5; i++) begin
            payload = {$urandom, $urandom};
            tick("R6");
        end
        check_eq("R6 held word", data_out, mw);

        // payload pass-through
        prbs_sel = 0;
        for (int i = 0; i < 8; i++) begin
            payload = {$urandom, $urandom};
            gen_en = $urandom_range(0, 1);
            tick("R5");
        end
        prbs_sel = 1; gen_en = 1;

        // every legal code
        set_cfg(4'h1, 0, 0); for (int i = 0; i < 20; i++) tick("R2");
        set_cfg(4'h2, 0, 0); for (int i = 0; i < 20; i++) tick("R2");
        set_cfg(4'h4, 0, 0); for (int i = 0; i < 20; i++) tick("R2");
        set_cfg(4'h8, 0, 0); for (int i = 0; i < 20; i++) tick("R2");
        checks++;
        if (data_out == 64'h0) begin
            errors++;
            $display("FAIL R10 actual=%h expected=nonzero", data_out);
        end
        set_cfg(4'h0, 1, 0); for (int i = 0; i < 20; i++) tick("R2");

        // illegal codes fall back
        set_cfg(4'h3, 0, 0); for (int i = 0; i < 6; i++) tick("R4");
        set_cfg(4'h1, 1, 0); for (int i = 0; i < 6; i++) tick("R4");
        set_cfg(4'h4, 0, 1); for (int i = 0; i < 6; i++) tick("R4");
        set_cfg(4'h0, 0, 1); for (int i = 0; i < 6; i++) tick("R4");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                case ($urandom_range(0, 6))
                    0: set_cfg(4'h1, 0, $urandom_range(0, 1));
                    1: set_cfg(4'h2, 0, $urandom_range(0, 1));
                    2: set_cfg(4'h4, 0, 0);
                    3: set_cfg(4'h8, 0, 0);
                    4: set_cfg(4'h0, 1, 0);
                    default: set_cfg(4'($urandom), 1'($urandom), 1'($urandom));
                endcase
            end
            gen_en   = ($urandom_range(0, 9) < 8);
            prbs_sel = ($urandom_range(0, 9) < 8);
            payload  = {$urandom, $urandom};
            tick("R7");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule